// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a small synchronous static RAM with a built-in two-bit burst address sequencer. All of its inputs (address, write data, write controls, burst controls and select) are sampled on the rising clock edge. A cycle either starts a new burst from the external address or continues the current one. Within a burst, the two low address bits come from an internal counter. That counter steps only when the advance input is high. It walks the four words of an aligned group in either ascending-wrap order or XOR order, depending on an order input sampled at the burst start.

A burst is opened by one of two address strobes. The processor strobe always opens a read and wins when both strobes are high. The controller strobe opens a cycle that obeys the write controls. A write either covers every lane at once (whole-word write) or only the lanes picked by a per-lane select, and the per-lane select is gated by a lane-write enable. Read data is not registered a second time: the word at the sampled address shows on the output in the cycle right after the capturing edge. The output is driven only while the asynchronous output enable is high.

Top module: `fts_burst_ram`

## Requirements
- R1: The operation of a cycle is set by the input values sampled at the rising edge. Changing the address input between edges does not alter the read data shown for the sampled address.
- R2: A cycle with select high and either strobe high loads the external address as the burst start. Its read or write acts on exactly that address.
- R3: In a continuing burst (select high, no strobe), the low two address bits step once per cycle with advance high. With advance low the same address is reused.
- R4: With order input 0 at burst start, beat k reaches low bits (start + k) mod 4. The upper address bits stay fixed.
- R5: With order input 1 at burst start, beat k reaches low bits start XOR k. The upper address bits stay fixed.
- R6: With whole-word write high, every lane of the word is written, regardless of the lane-select and lane-write-enable inputs.
- R7: Without whole-word write, a write occurs only when lane-write enable is high, and only to lanes whose lane-select bit is high. Lane k occupies data bits [9k+8:9k].
- R8: An edge with select low writes nothing and ends the burst. The next cycle drives no output, and advance without a new strobe does not restart the burst.
- R9: A read cycle's word appears on the output in the clock cycle that follows its capturing edge, with no additional register stage.
- R10: Data-drive follows output enable combinationally. Data-drive is high only in a read cycle with output enable high, and the data output is all zeros whenever data-drive is low.
- R11: When both strobes are high, the processor strobe takes priority: the cycle is a read and all write controls are ignored.
- R12: A cycle opened by the processor strobe is a read even when whole-word write is high. A cycle opened by the controller strobe obeys the write controls.
- R13: After reset no burst is active and data-drive is low until a strobe opens a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high |
| cpu_strb_i | input | 1 | Processor address strobe, read-only start, has priority |
| ctl_strb_i | input | 1 | Controller address strobe, start that obeys the write controls |
| step_i | input | 1 | Burst advance |
| addr_i | input | $clog2(DEPTH) | External word address |
| order_i | input | 1 | Burst order: 0 ascending-wrap, 1 XOR |
| wr_all_i | input | 1 | Whole-word write |
| lane_wr_en_i | input | 1 | Lane-write enable |
| lane_sel_i | input | LANES | Per-lane write select |
| wdata_i | input | LANES*9 | Write data |
| out_en_i | input | 1 | Asynchronous output enable |
| rdata_o | output | LANES*9 | Read data, zero when not driven |
| drive_o | output | 1 | Data-drive / output-valid |

## Verification
Several properties are checked on every clock cycle. Ascending-wrap stepping is checked, and XOR stepping is checked to keep the upper address bits while changing the low ones. A held burst is checked to keep its address. After a processor strobe the bench expects a read, and after a deselect edge it expects no write and no drive. Each lane write is checked to land at its address. The exact four-beat sequences for every start value in both orders cannot be shown by those per-cycle properties, and neither can lane merging for every select pattern or the data actually returned. Only the bench's sweeps show these, by comparing read data against a model of the array that is computed arithmetically.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int LANE_W = 9;

    typedef enum logic {
        ORD_ASCEND = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input burst_order_e ord);
        return (ord == ORD_XOR) ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/fts_lane_bank.sv
module fts_lane_bank
    import fts_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [LANE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [LANE_W-1:0] rdata_o
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

    AST_LANE_STORE: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)))
        else $error("lane write lost"); // R7

endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
    import fts_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic          cpu_strb_i,
    input  logic          ctl_strb_i,
    input  logic          step_i,
    input  logic [AW-1:0] addr_i,
    input  logic          order_i,
    input  logic          wr_req_i,
    output logic [AW-1:0] op_addr_o,
    output logic          op_wr_o,
    output logic [AW-1:0] cur_addr_o,
    output logic          rd_valid_o
);

    typedef struct packed {
        logic           active;
        burst_order_e   ord;
        logic [AW-3:0]  hi;
        logic [1:0]     start;
        logic [1:0]     cnt;
    } bstate_t;

    bstate_t st_q, st_d;
    logic    load, live, step;

    always_comb begin
        load = sel_i & (cpu_strb_i | ctl_strb_i);
        live = sel_i & (load | st_q.active);
        step = live & ~load & step_i;
        st_d = st_q;
        if (load) begin
            st_d.active = 1'b1;
            st_d.ord    = burst_order_e'(order_i);
            st_d.hi     = addr_i[AW-1:2];
            st_d.start  = addr_i[1:0];
            st_d.cnt    = 2'd0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 2'd1;
        end
        if (!sel_i) st_d.active = 1'b0;
    end

    assign op_addr_o = {st_d.hi, burst_low(st_d.start, st_d.cnt, st_d.ord)};
    assign op_wr_o   = live & ~cpu_strb_i & wr_req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            cur_addr_o <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            st_q       <= st_d;
            cur_addr_o <= op_addr_o;
            rd_valid_o <= live & ~op_wr_o;
        end
    end

    AST_ASCEND_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.ord == ORD_ASCEND) |=>
        (cur_addr_o[1:0] == $past(cur_addr_o[1:0]) + 2'd1 &&
         cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])))
        else $error("ascending step wrong"); // R4

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.ord == ORD_XOR) |=>
        (cur_addr_o[1:0] != $past(cur_addr_o[1:0]) &&
         cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])))
        else $error("xor step wrong"); // R5

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (live && !load && !step_i) |=> $stable(cur_addr_o))
        else $error("held burst moved"); // R3

endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int W  = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             cpu_strb_i,
    input  logic             ctl_strb_i,
    input  logic             step_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             order_i,
    input  logic             wr_all_i,
    input  logic             lane_wr_en_i,
    input  logic [LANES-1:0] lane_sel_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             out_en_i,
    output logic [W-1:0]     rdata_o,
    output logic             drive_o
);

    logic [AW-1:0]    op_addr, cur_addr;
    logic             op_wr, rd_valid, wr_req;
    logic [LANES-1:0] lane_we;
    logic [W-1:0]     rd_word;

    assign wr_req = wr_all_i | (lane_wr_en_i & (|lane_sel_i));

    fts_burst_seq #(.AW(AW)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sel_i),
        .cpu_strb_i (cpu_strb_i),
        .ctl_strb_i (ctl_strb_i),
        .step_i     (step_i),
        .addr_i     (addr_i),
        .order_i    (order_i),
        .wr_req_i   (wr_req),
        .op_addr_o  (op_addr),
        .op_wr_o    (op_wr),
        .cur_addr_o (cur_addr),
        .rd_valid_o (rd_valid)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_we[k] = op_wr & (wr_all_i | lane_sel_i[k]);
        fts_lane_bank #(.DEPTH(DEPTH)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .we_i    (lane_we[k]),
            .waddr_i (op_addr),
            .wdata_i (wdata_i[k*LANE_W +: LANE_W]),
            .raddr_i (cur_addr),
            .rdata_o (rd_word[k*LANE_W +: LANE_W])
        );
    end

    assign drive_o = out_en_i & rd_valid;
    assign rdata_o = drive_o ? rd_word : '0;

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !sel_i |-> (lane_we == '0))
        else $error("write while deselected"); // R8

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> !drive_o)
        else $error("drive after deselect"); // R8

    AST_CPU_STROBE_READS: assert property (@(posedge clk) disable iff (rst)
        (sel_i && cpu_strb_i) |=> (drive_o == out_en_i))
        else $error("processor strobe not a read"); // R11

endmodule

// File: tb/test_fts_burst_ram.sv
module test_fts_burst_ram;

    localparam int LANES = 2;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 18;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sel_i = 0, cpu_strb_i = 0, ctl_strb_i = 0, step_i = 0;
    logic [AW-1:0]    addr_i = '0;
    logic             order_i = 0, wr_all_i = 0, lane_wr_en_i = 0, out_en_i = 1;
    logic [LANES-1:0] lane_sel_i = '0;
    logic [W-1:0]     wdata_i = '0;
    logic [W-1:0]     rdata_o;
    logic             drive_o;

    int vecs = 0;
    int errs = 0;
    logic [W-1:0] model [DEPTH];

    fts_burst_ram #(.LANES(LANES), .DEPTH(DEPTH)) i_fts_burst_ram (
        .clk, .rst, .sel_i, .cpu_strb_i, .ctl_strb_i, .step_i, .addr_i,
        .order_i, .wr_all_i, .lane_wr_en_i, .lane_sel_i, .wdata_i,
        .out_en_i, .rdata_o, .drive_o
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        cpu_strb_i = 0; ctl_strb_i = 0; step_i = 0; wr_all_i = 0;
        lane_wr_en_i = 0; lane_sel_i = '0;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int a, input int salt);
        return W'((a * 37 + salt * 1031 + 5) & 18'h3ffff);
    endfunction

    function automatic logic [1:0] beat(input int ord, input int s, input int k);
        return (ord == 1) ? 2'(s ^ k) : 2'((s + k) % 4);
    endfunction

    task automatic wr_word(input int a, input logic [W-1:0] d);
        idle_in(); sel_i = 1; ctl_strb_i = 1; wr_all_i = 1;
        addr_i = AW'(a); wdata_i = d;
        tick();
        model[a] = d;
        idle_in();
    endtask

    task automatic rd_word(input int a, input string req);
        idle_in(); sel_i = 1; cpu_strb_i = 1; addr_i = AW'(a);
        tick();
        chk(req, rdata_o, model[a]);
        idle_in();
    endtask

    initial begin
        #1_500_000;
        errs++;
        $display("FAIL R9 watchdog expired actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        chk("R13 reset drive", 18'(drive_o), 18'd0);
        sel_i = 1; step_i = 1;
        tick();
        chk("R13 advance without strobe", 18'(drive_o), 18'd0);
        idle_in();

        // fill every word
        for (int a = 0; a < DEPTH; a++) wr_word(a, pat(a, 0));
        for (int a = 0; a < DEPTH; a += 17) rd_word(a, "R2 R9 fill read");

        // R1: address change between edges does not affect shown data
        idle_in(); sel_i = 1; cpu_strb_i = 1; addr_i = 8'd10;
        tick();
        addr_i = 8'd11; cpu_strb_i = 0;
        #2;
        chk("R1 sampled address", rdata_o, model[10]);
        idle_in();
        tick();

        // burst sweeps in both orders, every start
        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 4; s++) begin
                int base;
                base = 64 + (ord * 4 + s) * 4;
                idle_in(); sel_i = 1; order_i = ord[0];
                for (int k = 0; k < 4; k++) begin
                    ctl_strb_i = (k == 0); step_i = (k != 0); wr_all_i = 1;
                    addr_i = AW'(base + s);
                    wdata_i = pat(base + k, 7 + ord);
                    tick();
                    model[base + beat(ord, s, k)] = pat(base + k, 7 + ord);
                    chk("R12 write cycle not driven", 18'(drive_o), 18'd0);
                end
                idle_in(); order_i = ord[0];
                for (int k = 0; k < 4; k++) begin
                    cpu_strb_i = (k == 0); step_i = (k != 0);
                    addr_i = AW'(base + s);
                    tick();
                    chk(ord ? "R5 xor beat" : "R4 ascending beat", rdata_o,
                        model[base + beat(ord, s, k)]);
                    if (k == 1) begin
                        cpu_strb_i = 0; step_i = 0;
                        tick();
                        chk("R3 held burst", rdata_o, model[base + beat(ord, s, 1)]);
                    end
                end
                idle_in(); order_i = 0;
            end
        end

        // lane writes
        for (int m = 0; m < 4; m++) begin
            for (int en = 0; en < 2; en++) begin
                logic [W-1:0] d, e;
                int a;
                a = 150 + m * 2 + en;
                d = ~pat(a, 3);
                idle_in(); sel_i = 1; ctl_strb_i = 1; lane_wr_en_i = en[0];
                lane_sel_i = 2'(m); addr_i = AW'(a); wdata_i = d;
                tick();
                e = model[a];
                if (en == 1) begin
                    if (m[0]) e[8:0]  = d[8:0];
                    if (m[1]) e[17:9] = d[17:9];
                end
                model[a] = e;
                idle_in();
                rd_word(a, "R7 lane write");
            end
        end

        // R6: whole-word write ignores lane controls
        idle_in(); sel_i = 1; ctl_strb_i = 1; wr_all_i = 1; lane_wr_en_i = 0;
        lane_sel_i = 2'b00; addr_i = 8'd170; wdata_i = 18'h2a5a5;
        tick();
        model[170] = 18'h2a5a5;
        rd_word(170, "R6 whole-word write");

        // R12: processor strobe with whole-word write is a read
        idle_in(); sel_i = 1; cpu_strb_i = 1; wr_all_i = 1; addr_i = 8'd171;
        wdata_i = 18'h11111;
        tick();
        chk("R12 cpu strobe reads", rdata_o, model[171]);
        rd_word(171, "R12 no write by cpu strobe");

        // R11: both strobes -> read, write ignored
        idle_in(); sel_i = 1; cpu_strb_i = 1; ctl_strb_i = 1; wr_all_i = 1;
        addr_i = 8'd172; wdata_i = 18'h22222;
        tick();
        chk("R11 both strobes drive", 18'(drive_o), 18'd1);
        chk("R11 both strobes data", rdata_o, model[172]);
        rd_word(172, "R11 no write on both strobes");

        // R8: deselect
        idle_in(); sel_i = 0; ctl_strb_i = 1; wr_all_i = 1; addr_i = 8'd173;
        wdata_i = 18'h33333;
        tick();
        chk("R8 deselect no drive", 18'(drive_o), 18'd0);
        rd_word(173, "R8 deselect no write");
        idle_in(); sel_i = 1; cpu_strb_i = 1; addr_i = 8'd176;
        tick();
        idle_in(); sel_i = 0;
        tick();
        chk("R8 mid-burst deselect", 18'(drive_o), 18'd0);
        sel_i = 1; step_i = 1;
        tick();
        chk("R8 burst ended", 18'(drive_o), 18'd0);

        // R10: output enable is combinational
        idle_in(); sel_i = 1; cpu_strb_i = 1; addr_i = 8'd174; out_en_i = 0;
        tick();
        chk("R10 oe low drive", 18'(drive_o), 18'd0);
        chk("R10 oe low data", rdata_o, 18'd0);
        out_en_i = 1;
        #1;
        chk("R10 oe high drive", 18'(drive_o), 18'd1);
        chk("R10 oe high data", rdata_o, model[174]);
        idle_in();

        // R13: reset mid-burst
        rst = 1;
        tick();
        rst = 0;
        tick();
        chk("R13 after reset", 18'(drive_o), 18'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule